// File: doc/BRIEF.md
# Multi-Level Repetition Address Generator

This block produces the address stream and timing for one port of a memory-like resource. Software-visible control arrives as 32-bit configuration words on a write port tagged with a port number. A setup word records an initial address into one of several option slots and clears the loop program. Each loop word appends one nested loop level with its own iteration count, address step and inter-iteration pause. An extension word widens the most recently appended level by supplying the upper bits of those three fields. A transition word sets a lead-in delay that elapses between the start event and the first access.

When a start event arrives while the block is idle, the generator picks the initial address of the option named on the start-option input. It then walks the loop nest with the innermost level varying fastest. Each access cycle shows the address with a valid strobe, and the declared pauses appear as cycles with valid low. After the last access, a single-cycle done pulse is raised and the block returns to idle. The memory behind the addresses is not part of this block.

Top module: `rep_addr_gen`

## Requirements
- R1: After reset, addrValid and done are 0, every option's initial address is 0 and the loop program is empty, so a start event yields exactly one access at address 0 followed by done.
- R2: A word with bits [31:30]=0 is a setup word: bits [29:28] name the option slot, bit 27 set means the slot takes the value on scalarVal at the time of the write instead of bits [15:0], and the write clears the loop program (no levels, transition delay 0).
- R3: A word with bits [31:30]=1 appends a loop level (the first appended level is innermost) with iteration count bits [21:14], step bits [13:7] and pause bits [6:0]; loop words beyond LEVELS levels are ignored.
- R4: A word with bits [31:30]=2 writes bits [21:14], [13:7] and [6:0] as the upper 8, 7 and 7 bits of the iteration count, step and pause of the most recently appended level; with no level present it is ignored.
- R5: A word with bits [31:30]=3 sets the transition delay from bits [21:0]; after the start edge, valid stays low for that many cycles, and the first access appears in the cycle that follows them (the cycle right after the start edge when the delay is 0).
- R6: Access k carries the address initial + sum over levels of index times step, modulo 2^16; the innermost index advances fastest and an iteration count of N gives N+1 iterations of that level.
- R7: After an access, the level that advances next is the lowest level that has not reached its count; valid then stays low for that level's pause before the next access; no pause follows the last access.
- R8: done is high for exactly one cycle, in the cycle after the last access; the block is then idle and accepts a new start event.
- R9: Configuration writes and start events received while the generator is running are ignored, as are writes whose cfgPort differs from PORT_ID (default 0).
- R10: The start-option input sampled with the start event selects which option slot supplies the initial address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgWrite | input | 1 | Configuration write strobe |
| cfgPort | input | 2 | Port number the write is addressed to |
| cfgWord | input | 32 | Configuration word |
| scalarVal | input | 16 | Scalar register value used by dynamic setup words |
| startEvt | input | 1 | Start event |
| startOpt | input | 2 | Option slot used by the start event |
| addrOut | output | 16 | Generated address |
| addrValid | output | 1 | High in access cycles |
| done | output | 1 | One-cycle end-of-sequence pulse |

## Verification
The assertions watch, on every cycle, that a done pulse never lasts two cycles and returns the block to idle, that a nonzero pause drops valid right after the access, that a zero lead-in gives valid right after the start, that an idle block never shows valid, and that the stored program stays frozen while running. Whether the address sequence follows the nested-loop formula, including wrap, extension bits, option selection and the ignored writes, only the bench's scenarios can show, by comparing each cycle against a stream computed from the loop model.

// File: rtl/repgen_pkg.sv
package repgen_pkg;
  localparam int WORD_W    = 32;
  localparam int ADDR_W    = 16;
  localparam int ITER_LO_W = 8;
  localparam int STEP_LO_W = 7;
  localparam int DLY_LO_W  = 7;
  localparam int ITER_W    = 2 * ITER_LO_W;
  localparam int STEP_W    = 2 * STEP_LO_W;
  localparam int DLY_W     = 2 * DLY_LO_W;
  localparam int TRANS_W   = 22;
  localparam int CNT_W     = (TRANS_W > DLY_W) ? TRANS_W : DLY_W;

  typedef enum logic [1:0] {
    KIND_SETUP = 2'd0,
    KIND_LOOP  = 2'd1,
    KIND_EXT   = 2'd2,
    KIND_TRANS = 2'd3
  } cfgKind_t;

  typedef struct packed {
    logic [ITER_W-1:0] iter;
    logic [STEP_W-1:0] step;
    logic [DLY_W-1:0]  delay;
  } loopLevel_t;

  typedef struct packed {
    logic load;
    logic advance;
  } ctrlStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_RUN,
    ST_GAP,
    ST_FIN
  } seqState_t;
endpackage

// File: rtl/rep_cfg_store.sv
module rep_cfg_store
  import repgen_pkg::*;
#(
  parameter int LEVELS = 4,
  parameter int OPTIONS = 4,
  parameter logic [1:0] PORT_ID = 2'd0
) (
  input  logic clk,
  input  logic rstN,
  input  logic busy,
  input  logic cfgWrite,
  input  logic [1:0] cfgPort,
  input  logic [WORD_W-1:0] cfgWord,
  input  logic [ADDR_W-1:0] scalarVal,
  output loopLevel_t [LEVELS-1:0] levels,
  output logic [OPTIONS-1:0][ADDR_W-1:0] initAddr,
  output logic [TRANS_W-1:0] transDelay
);
  localparam int LVL_CNT_W = $clog2(LEVELS + 1);
  localparam int OPT_W = (OPTIONS > 1) ? $clog2(OPTIONS) : 1;

  logic accept;
  logic setupHit, loopHit, extHit, transHit;
  logic [LVL_CNT_W-1:0] lvlCnt;
  cfgKind_t kind;
  logic [OPT_W-1:0] optSel;
  logic [ADDR_W-1:0] setupVal;
  wire unusedCfgBits = ^cfgWord[26:22];

  assign kind     = cfgKind_t'(cfgWord[31:30]);
  assign accept   = cfgWrite && !busy && (cfgPort == PORT_ID);
  assign setupHit = accept && (kind == KIND_SETUP);
  assign loopHit  = accept && (kind == KIND_LOOP);
  assign extHit   = accept && (kind == KIND_EXT);
  assign transHit = accept && (kind == KIND_TRANS);
  assign optSel   = cfgWord[28 +: OPT_W];
  assign setupVal = cfgWord[27] ? scalarVal : cfgWord[ADDR_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lvlCnt <= '0;
    end else if (setupHit) begin
      lvlCnt <= '0;
    end else if (loopHit && (lvlCnt < LVL_CNT_W'(LEVELS))) begin
      lvlCnt <= lvlCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      transDelay <= '0;
    end else if (setupHit) begin
      transDelay <= '0;
    end else if (transHit) begin
      transDelay <= cfgWord[TRANS_W-1:0];
    end
  end

  for (genvar l = 0; l < LEVELS; l++) begin : gLevel
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        levels[l].iter  <= '0;
        levels[l].step  <= STEP_W'(1);
        levels[l].delay <= '0;
      end else if (setupHit) begin
        levels[l].iter  <= '0;
        levels[l].step  <= STEP_W'(1);
        levels[l].delay <= '0;
      end else if (loopHit && (lvlCnt == LVL_CNT_W'(l))) begin
        levels[l].iter  <= {{ITER_LO_W{1'b0}}, cfgWord[21:14]};
        levels[l].step  <= {{STEP_LO_W{1'b0}}, cfgWord[13:7]};
        levels[l].delay <= {{DLY_LO_W{1'b0}}, cfgWord[6:0]};
      end else if (extHit && (lvlCnt == LVL_CNT_W'(l + 1))) begin
        levels[l].iter[ITER_W-1:ITER_LO_W]  <= cfgWord[21:14];
        levels[l].step[STEP_W-1:STEP_LO_W]  <= cfgWord[13:7];
        levels[l].delay[DLY_W-1:DLY_LO_W]   <= cfgWord[6:0];
      end
    end
  end

  for (genvar o = 0; o < OPTIONS; o++) begin : gOption
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        initAddr[o] <= '0;
      end else if (setupHit && (optSel == OPT_W'(o))) begin
        initAddr[o] <= setupVal;
      end
    end
  end

  // R9: the stored program does not move while a sequence runs
  assert_frozen_while_busy_R9 : assert property (@(posedge clk) disable iff (!rstN)
    busy |=> ($stable(lvlCnt) && $stable(transDelay) && $stable(initAddr)));

  // R3: never more levels than the nest holds
  assert_level_bound_R3 : assert property (@(posedge clk) disable iff (!rstN)
    lvlCnt <= LVL_CNT_W'(LEVELS));
endmodule

// File: rtl/rep_addr_path.sv
module rep_addr_path
  import repgen_pkg::*;
#(
  parameter int LEVELS = 4,
  parameter int OPTIONS = 4
) (
  input  logic clk,
  input  logic rstN,
  input  ctrlStrobe_t stb,
  input  logic [1:0] startOpt,
  input  loopLevel_t [LEVELS-1:0] levels,
  input  logic [OPTIONS-1:0][ADDR_W-1:0] initAddr,
  output logic [ADDR_W-1:0] addrOut,
  output logic lastAccess,
  output logic [DLY_W-1:0] gapDelay
);
  localparam int OPT_W = (OPTIONS > 1) ? $clog2(OPTIONS) : 1;

  logic [LEVELS-1:0][ITER_W-1:0] idx;
  logic [LEVELS-1:0][ADDR_W-1:0] base;
  logic [LEVELS-1:0][ADDR_W-1:0] nextBase;
  logic [LEVELS-1:0] levelDone;
  logic [LEVELS-1:0] advSel;
  logic [LEVELS-1:0] lowerMask;
  logic [ADDR_W-1:0] advAddr;
  logic [ADDR_W-1:0] startAddr;
  logic [OPT_W-1:0] optIdx;
  wire unusedOptBits = ^startOpt;

  assign optIdx    = startOpt[OPT_W-1:0];
  assign startAddr = initAddr[optIdx];

  for (genvar l = 0; l < LEVELS; l++) begin : gCmp
    assign levelDone[l] = (idx[l] == levels[l].iter);
    assign nextBase[l]  = base[l] + ADDR_W'(levels[l].step);
  end

  always_comb begin
    logic found;
    found = 1'b0;
    advSel = '0;
    for (int l = 0; l < LEVELS; l++) begin
      if (!found && !levelDone[l]) begin
        advSel[l] = 1'b1;
        found = 1'b1;
      end
    end
  end

  assign lowerMask  = advSel - 1'b1;
  assign lastAccess = &levelDone;

  always_comb begin
    advAddr  = '0;
    gapDelay = '0;
    for (int l = 0; l < LEVELS; l++) begin
      if (advSel[l]) begin
        advAddr  = advAddr | nextBase[l];
        gapDelay = gapDelay | levels[l].delay;
      end
    end
  end

  for (genvar l = 0; l < LEVELS; l++) begin : gIdx
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        idx[l]  <= '0;
        base[l] <= '0;
      end else if (stb.load) begin
        idx[l]  <= '0;
        base[l] <= startAddr;
      end else if (stb.advance) begin
        if (advSel[l]) begin
          idx[l]  <= idx[l] + 1'b1;
          base[l] <= nextBase[l];
        end else if (lowerMask[l]) begin
          idx[l]  <= '0;
          base[l] <= advAddr;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrOut <= '0;
    end else if (stb.load) begin
      addrOut <= startAddr;
    end else if (stb.advance) begin
      addrOut <= advAddr;
    end
  end

  // R6: at most one level advances per access
  assert_single_advance_R6 : assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(advSel));

  // R6: an innermost step moves the address by that level's step
  assert_inner_step_R6 : assert property (@(posedge clk) disable iff (!rstN)
    (stb.advance && advSel[0]) |=>
      (addrOut == $past(addrOut) + ADDR_W'($past(levels[0].step))));

  // R10: the start loads the selected option's initial address
  assert_load_init_R10 : assert property (@(posedge clk) disable iff (!rstN)
    stb.load |=> (addrOut == $past(startAddr)));
endmodule

// File: rtl/rep_seq_ctrl.sv
module rep_seq_ctrl
  import repgen_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic startEvt,
  input  logic lastAccess,
  input  logic [DLY_W-1:0] gapDelay,
  input  logic [TRANS_W-1:0] transDelay,
  output ctrlStrobe_t stb,
  output logic addrValid,
  output logic done,
  output logic busy
);
  seqState_t state;
  logic [CNT_W-1:0] cnt;

  assign busy        = (state != ST_IDLE);
  assign addrValid   = (state == ST_RUN);
  assign done        = (state == ST_FIN);
  assign stb.load    = (state == ST_IDLE) && startEvt;
  assign stb.advance = (state == ST_RUN) && !lastAccess;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (startEvt) begin
          if (transDelay != '0) begin
            state <= ST_PRE;
            cnt   <= CNT_W'(transDelay);
          end else begin
            state <= ST_RUN;
          end
        end
        ST_PRE, ST_GAP: begin
          if (cnt == CNT_W'(1)) state <= ST_RUN;
          else cnt <= cnt - 1'b1;
        end
        ST_RUN: begin
          if (lastAccess) begin
            state <= ST_FIN;
          end else if (gapDelay != '0) begin
            state <= ST_GAP;
            cnt   <= CNT_W'(gapDelay);
          end
        end
        ST_FIN: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R8: done lasts one cycle and leaves the block idle
  assert_done_pulse_R8 : assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!done && !busy));

  // R7: a nonzero pause drops valid right after the access
  assert_gap_quiet_R7 : assert property (@(posedge clk) disable iff (!rstN)
    (stb.advance && (gapDelay != '0)) |=> !addrValid);

  // R5: with no lead-in the first access follows the start edge
  assert_prompt_start_R5 : assert property (@(posedge clk) disable iff (!rstN)
    (stb.load && (transDelay == '0)) |=> addrValid);

  // R1: an idle block shows neither valid nor done
  assert_idle_silent_R1 : assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!addrValid && !done));
endmodule

// File: rtl/rep_addr_gen.sv
module rep_addr_gen
  import repgen_pkg::*;
#(
  parameter int LEVELS = 4,
  parameter int OPTIONS = 4,
  parameter logic [1:0] PORT_ID = 2'd0
) (
  input  logic clk,
  input  logic rstN,
  input  logic cfgWrite,
  input  logic [1:0] cfgPort,
  input  logic [31:0] cfgWord,
  input  logic [15:0] scalarVal,
  input  logic startEvt,
  input  logic [1:0] startOpt,
  output logic [15:0] addrOut,
  output logic addrValid,
  output logic done
);
  loopLevel_t [LEVELS-1:0] levels;
  logic [OPTIONS-1:0][ADDR_W-1:0] initAddr;
  logic [TRANS_W-1:0] transDelay;
  logic [DLY_W-1:0] gapDelay;
  logic lastAccess;
  logic busy;
  ctrlStrobe_t stb;

  rep_cfg_store #(.LEVELS(LEVELS), .OPTIONS(OPTIONS), .PORT_ID(PORT_ID)) uCfg (
    .clk(clk), .rstN(rstN), .busy(busy),
    .cfgWrite(cfgWrite), .cfgPort(cfgPort), .cfgWord(cfgWord), .scalarVal(scalarVal),
    .levels(levels), .initAddr(initAddr), .transDelay(transDelay)
  );

  rep_addr_path #(.LEVELS(LEVELS), .OPTIONS(OPTIONS)) uPath (
    .clk(clk), .rstN(rstN), .stb(stb), .startOpt(startOpt),
    .levels(levels), .initAddr(initAddr),
    .addrOut(addrOut), .lastAccess(lastAccess), .gapDelay(gapDelay)
  );

  rep_seq_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .startEvt(startEvt),
    .lastAccess(lastAccess), .gapDelay(gapDelay), .transDelay(transDelay),
    .stb(stb), .addrValid(addrValid), .done(done), .busy(busy)
  );
endmodule

// File: tb/tb_rep_addr_gen.sv
module tb_rep_addr_gen;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWrite = 1'b0;
  logic [1:0] cfgPort = 2'd0;
  logic [31:0] cfgWord = '0;
  logic [15:0] scalarVal = '0;
  logic startEvt = 1'b0;
  logic [1:0] startOpt = 2'd0;
  logic [15:0] addrOut;
  logic addrValid;
  logic done;

  int vecCount = 0;
  int failCount = 0;
  int cycles = 0;
  bit finished = 0;

  // bench model of the stored program
  int mInit[4];
  int mIter[4];
  int mStep[4];
  int mDelay[4];
  int mCnt;
  int mTrans;
  logic [17:0] expQ[$];

  rep_addr_gen dut (
    .clk(clk), .rstN(rstN), .cfgWrite(cfgWrite), .cfgPort(cfgPort), .cfgWord(cfgWord),
    .scalarVal(scalarVal), .startEvt(startEvt), .startOpt(startOpt),
    .addrOut(addrOut), .addrValid(addrValid), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !finished) begin
      failCount++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < %0d", cycles, WATCHDOG);
      $display("== %0d vectors applied, %0d miscompares ==", vecCount, failCount);
      $finish;
    end
  end

  function automatic logic [31:0] mkSetup(int opt, bit dyn, int addr);
    return {2'd0, opt[1:0], dyn, 11'd0, addr[15:0]};
  endfunction
  function automatic logic [31:0] mkLoop(int it, int st, int dl);
    return {2'd1, 8'd0, it[7:0], st[6:0], dl[6:0]};
  endfunction
  function automatic logic [31:0] mkExt(int it, int st, int dl);
    return {2'd2, 8'd0, it[7:0], st[6:0], dl[6:0]};
  endfunction
  function automatic logic [31:0] mkTrans(int dl);
    return {2'd3, 8'd0, dl[21:0]};
  endfunction

  task automatic modelClear();
    for (int l = 0; l < 4; l++) begin
      mIter[l] = 0; mStep[l] = 1; mDelay[l] = 0;
    end
    mCnt = 0;
    mTrans = 0;
  endtask

  // model of R2..R5 field decoding
  task automatic modelApply(logic [31:0] w);
    case (w[31:30])
      2'd0: begin
        mInit[w[29:28]] = w[27] ? int'(scalarVal) : int'(w[15:0]);
        modelClear();
      end
      2'd1: if (mCnt < 4) begin
        mIter[mCnt] = w[21:14]; mStep[mCnt] = w[13:7]; mDelay[mCnt] = w[6:0];
        mCnt++;
      end
      2'd2: if (mCnt > 0) begin
        mIter[mCnt-1]  = (int'(w[21:14]) << 8) | (mIter[mCnt-1] & 8'hFF);
        mStep[mCnt-1]  = (int'(w[13:7]) << 7) | (mStep[mCnt-1] & 7'h7F);
        mDelay[mCnt-1] = (int'(w[6:0]) << 7) | (mDelay[mCnt-1] & 7'h7F);
      end
      default: mTrans = w[21:0];
    endcase
  endtask

  task automatic cfgWr(logic [1:0] port, logic [31:0] w, bit expectAccept);
    cfgWrite = 1'b1; cfgPort = port; cfgWord = w;
    @(negedge clk);
    cfgWrite = 1'b0;
    if (expectAccept) modelApply(w);
  endtask

  // expected per-cycle stream {done, valid, addr} from R5..R8
  task automatic buildExp(int opt);
    int idx[4];
    int a;
    int adv;
    expQ.delete();
    for (int t = 0; t < mTrans; t++) expQ.push_back(18'd0);
    for (int l = 0; l < 4; l++) idx[l] = 0;
    forever begin
      a = mInit[opt];
      for (int l = 0; l < 4; l++) a += idx[l] * mStep[l];
      expQ.push_back({2'b01, a[15:0]});
      adv = -1;
      for (int l = 3; l >= 0; l--) if (idx[l] < mIter[l]) adv = l;
      if (adv < 0) break;
      idx[adv]++;
      for (int j = 0; j < adv; j++) idx[j] = 0;
      for (int d = 0; d < mDelay[adv]; d++) expQ.push_back(18'd0);
    end
    expQ.push_back({2'b10, 16'd0});
    expQ.push_back(18'd0);
  endtask

  // runs one sequence; disturb=1 injects writes and a start while running (R9)
  task automatic runSeq(string tag, int opt, bit disturb);
    int bad;
    buildExp(opt);
    startEvt = 1'b1; startOpt = opt[1:0];
    @(negedge clk);
    startEvt = 1'b0;
    bad = 0;
    for (int k = 0; k < expQ.size(); k++) begin
      logic [17:0] e;
      e = expQ[k];
      vecCount++;
      if (addrValid !== e[16] || done !== e[17] || (e[16] && addrOut !== e[15:0])) begin
        failCount++;
        if (bad < 5)
          $display("FAIL %s cycle %0d: actual valid=%0b done=%0b addr=%h expected valid=%0b done=%0b addr=%h",
                   tag, k, addrValid, done, addrOut, e[16], e[17], e[15:0]);
        bad++;
      end
      if (disturb && k == 0) begin
        cfgWrite = 1'b1; cfgPort = 2'd0; cfgWord = mkSetup(opt, 1'b0, 16'h5555);
      end else if (disturb && k == 1) begin
        cfgWord = mkLoop(3, 3, 0); startEvt = 1'b1;
      end else if (disturb && k == 2) begin
        cfgWrite = 1'b0; startEvt = 1'b0;
      end
      @(negedge clk);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int o = 0; o < 4; o++) mInit[o] = 0;
    modelClear();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    vecCount++;
    if (addrValid !== 1'b0 || done !== 1'b0) begin
      failCount++;
      $display("FAIL R1 reset: actual valid=%0b done=%0b expected 0 0", addrValid, done);
    end
    runSeq("R1 empty program", 0, 0);

    // R2 R3 R5 R6 R7 R8: two-level nest with lead-in and outer pause
    cfgWr(2'd0, mkSetup(0, 0, 16'h0100), 1);
    cfgWr(2'd0, mkLoop(2, 4, 0), 1);
    cfgWr(2'd0, mkLoop(1, 16, 2), 1);
    cfgWr(2'd0, mkTrans(3), 1);
    runSeq("R5 R6 R7 nest", 0, 0);

    // R2 R10: dynamic initial address in option 1
    scalarVal = 16'hABCD;
    cfgWr(2'd0, mkSetup(1, 1, 16'h0011), 1);
    cfgWr(2'd0, mkLoop(3, 1, 1), 1);
    scalarVal = 16'h0000;
    runSeq("R2 R10 dynamic opt1", 1, 0);

    // R6: address wrap modulo 2^16
    cfgWr(2'd0, mkSetup(2, 0, 16'hFFFE), 1);
    cfgWr(2'd0, mkLoop(3, 1, 0), 1);
    runSeq("R6 wrap", 2, 0);
    runSeq("R10 option0 kept", 0, 0);

    // R4: extension widens count and step
    cfgWr(2'd0, mkSetup(0, 0, 16'h0000), 1);
    cfgWr(2'd0, mkLoop(2, 3, 0), 1);
    cfgWr(2'd0, mkExt(1, 1, 0), 1);
    runSeq("R4 ext iter step", 0, 0);

    // R4: extension widens pause; extension with no level ignored
    cfgWr(2'd0, mkSetup(3, 0, 16'h0200), 1);
    cfgWr(2'd0, mkExt(5, 5, 5), 1);
    cfgWr(2'd0, mkLoop(1, 1, 2), 1);
    cfgWr(2'd0, mkExt(0, 0, 1), 1);
    runSeq("R4 ext delay and no-level ext", 3, 0);

    // R3: fifth loop word ignored
    cfgWr(2'd0, mkSetup(0, 0, 16'h1000), 1);
    for (int l = 0; l < 5; l++) cfgWr(2'd0, mkLoop(1, 1 << l, 0), 1);
    runSeq("R3 level limit", 0, 0);

    // R9: writes and start while running are ignored
    cfgWr(2'd0, mkSetup(0, 0, 16'h0040), 1);
    cfgWr(2'd0, mkLoop(2, 2, 1), 1);
    runSeq("R9 busy writes", 0, 1);
    runSeq("R9 after busy writes", 0, 0);

    // R9: write to another port ignored
    cfgWr(2'd1, mkSetup(0, 0, 16'h7777), 0);
    cfgWr(2'd1, mkLoop(5, 5, 5), 0);
    runSeq("R9 wrong port", 0, 0);

    // R3 R4 R6 R7: constrained random programs
    for (int r = 0; r < 40; r++) begin
      int opt, nl;
      opt = $urandom_range(0, 3);
      scalarVal = 16'($urandom);
      cfgWr(2'd0, mkSetup(opt, $urandom_range(0, 1), $urandom), 1);
      nl = $urandom_range(0, 5);
      for (int l = 0; l < nl; l++) begin
        cfgWr(2'd0, mkLoop($urandom_range(0, 3), $urandom_range(0, 127), $urandom_range(0, 3)), 1);
        if ($urandom_range(0, 3) == 0)
          cfgWr(2'd0, mkExt(0, $urandom_range(0, 127), 0), 1);
      end
      cfgWr(2'd0, mkTrans($urandom_range(0, 5)), 1);
      runSeq("R6 R7 random", opt, 0);
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, failCount);
    $finish;
  end
endmodule